// File: doc/BRIEF.md
# Graphics Aperture Address Translator

This block turns addresses that fall inside a graphics aperture into physical addresses. It has no translation cache: every accepted request reads its own entry from an external remapping table held in SRAM. The configured page size, 4 kB or 4 MB, selects which bits of the aperture offset index the table. The fetched entry is checked for even parity and for a set valid bit. Its page frame field is then joined to the page offset taken from the request address. Requests that fall below the aperture base, or 32 GB or more above it, are rejected without any table read.

Requests arrive on a valid/ready handshake and are accepted one per cycle, in order. The SRAM read port has a fixed one-cycle latency. The translated address, an error flag and a two-bit cause leave on a valid/ready response port. The block assumes that the SRAM keeps its read data unchanged until the next read enable. The aperture base is given in 4 MB granules, so the low 22 bits of the base are always zero. Table writes are handled elsewhere.

Top module: `gart_xlate`

## Requirements
- R1: After reset, respValid is low and reqReady is high.
- R2: With pageLarge low, an accepted in-range request drives sramRdEn high in its acceptance cycle, with sramAddr equal to bits 34:12 of (reqAddr - base).
- R3: With pageLarge high, sramAddr carries bits 34:22 of (reqAddr - base), zero-extended to 23 bits.
- R4: A request whose address is below the base, or whose offset from the base is 2^35 or more, is answered with cause 1 and starts no SRAM read. An offset of 2^35-1 is still translated.
- R5: An entry with an odd number of ones across all 32 bits (parity bit 31 included) gives cause 2.
- R6: An entry with correct parity whose valid bit 30 is clear gives cause 3. When both faults are present, cause 2 takes priority over cause 3.
- R7: On success (cause 0), respAddr is {entry[27:0], reqAddr[11:0]} for 4 kB pages and {entry[17:0], reqAddr[21:0]} for 4 MB pages.
- R8: When the cause is not 0, respErr is high and respAddr is zero. When the cause is 0, respErr is low.
- R9: Responses come out in acceptance order. If a request is accepted at clock edge n and the response port is not stalled, respValid is high after edge n+1. While no response is pending, reqReady stays high.
- R10: While respValid is high and respReady is low, respValid, respAddr, respErr and respCause hold, and no response is lost.
- R11: Every accepted in-range request issues its own SRAM read, even when it repeats an earlier address. sramRdEn is never high outside an acceptance.
- R12: The page size is sampled when a request is accepted. Changing pageLarge while that request is in flight does not alter its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pageLarge | input | 1 | 1 selects 4 MB pages, 0 selects 4 kB pages |
| apertureBase | input | 18 | Aperture base address in 4 MB granules |
| reqValid | input | 1 | Request valid |
| reqReady | output | 1 | Request can be accepted |
| reqAddr | input | 40 | Address to translate |
| sramRdEn | output | 1 | Table read enable |
| sramAddr | output | 23 | Table entry index |
| sramRdData | input | 32 | Entry read back one cycle after sramRdEn |
| respValid | output | 1 | Response valid |
| respReady | input | 1 | Response consumer ready |
| respAddr | output | 40 | Translated physical address, zero on error |
| respErr | output | 1 | Translation failed |
| respCause | output | 2 | 0 ok, 1 out of range, 2 parity, 3 entry invalid |

## Verification
The bench goes after the edges of the range check: the base itself, the last byte below 32 GB, exactly 32 GB, and one byte below the base. A wrong borrow or width in the subtraction would translate a request that must be rejected, or reject the last valid offset. It repeats indexes and flips pageLarge while requests are in flight. A design that cached entries or read the page size late would then skip SRAM reads or merge the offset at the wrong split point. Random response stalls catch a pipeline that drops or overwrites a response, or that uses stale SRAM data once the read data has moved on.

// File: rtl/gart_pkg.sv
`timescale 1ns/1ps
package gart_pkg;
  localparam int ADDR_W      = 40;  // request and physical address width
  localparam int SPACE_LOG2  = 35;  // translatable window is 2^35 bytes
  localparam int SMALL_SHIFT = 12;  // 4 kB page
  localparam int LARGE_SHIFT = 22;  // 4 MB page
  localparam int ENTRY_W     = 32;  // table entry width

  typedef enum logic [1:0] {
    CAUSE_NONE    = 2'd0,
    CAUSE_RANGE   = 2'd1,
    CAUSE_PARITY  = 2'd2,
    CAUSE_INVALID = 2'd3
  } xlate_cause_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadS1;    // capture an accepted request
    logic loadResp;  // move stage 1 into the response register
    logic sramRd;    // issue a table read
  } xlate_strobe_t;
endpackage

// File: rtl/gart_ctrl.sv
`timescale 1ns/1ps
module gart_ctrl
  import gart_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          reqValid,
  input  logic          inRange,
  input  logic          respReady,
  output logic          reqReady,
  output logic          respValid,
  output xlate_strobe_t strobe
);
  logic s1Valid;
  logic respValidQ;
  logic advance;
  logic accept;

  // the response register can take stage 1 when it is empty or draining
  assign advance   = !respValidQ || respReady;
  assign reqReady  = !s1Valid || advance;
  assign accept    = reqValid && reqReady;
  assign respValid = respValidQ;

  always_comb begin
    strobe          = '0;
    strobe.loadS1   = accept;
    strobe.loadResp = s1Valid && advance;
    strobe.sramRd   = accept && inRange;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1Valid    <= 1'b0;
      respValidQ <= 1'b0;
    end else begin
      s1Valid    <= accept || (s1Valid && !advance);
      respValidQ <= (s1Valid && advance) || (respValidQ && !respReady);
    end
  end
endmodule

// File: rtl/gart_dpath.sv
`timescale 1ns/1ps
module gart_dpath
  import gart_pkg::*;
#(
  parameter int AddrW      = ADDR_W,
  parameter int SpaceLog2  = SPACE_LOG2,
  parameter int SmallShift = SMALL_SHIFT,
  parameter int LargeShift = LARGE_SHIFT,
  parameter int EntryW     = ENTRY_W,
  localparam int IdxW      = SpaceLog2 - SmallShift,
  localparam int BaseW     = AddrW - LargeShift,
  localparam int PageW     = AddrW - SmallShift,
  localparam int GranW     = LargeShift - SmallShift,
  localparam int FrameS    = AddrW - SmallShift,
  localparam int FrameL    = AddrW - LargeShift,
  localparam int ValidBit  = EntryW - 2
)(
  input  logic              clk,
  input  logic              rst,
  input  xlate_strobe_t     strobe,
  input  logic              pageLarge,
  input  logic [BaseW-1:0]  apertureBase,
  input  logic [AddrW-1:0]  reqAddr,
  input  logic [EntryW-1:0] sramRdData,
  output logic              inRange,
  output logic [IdxW-1:0]   sramAddr,
  output logic [AddrW-1:0]  respAddr,
  output logic              respErr,
  output xlate_cause_e      respCause
);
  // page-granular offset from the base, with a borrow bit on top
  logic [PageW:0] pageDiff;
  assign pageDiff = {1'b0, reqAddr[AddrW-1:SmallShift]}
                  - {1'b0, apertureBase, {GranW{1'b0}}};

  assign inRange  = !pageDiff[PageW] && (pageDiff[PageW-1:IdxW] == '0);
  assign sramAddr = pageLarge ? IdxW'(pageDiff[IdxW-1:GranW])
                              : pageDiff[IdxW-1:0];

  // stage 1: request held while its entry is read
  logic [LargeShift-1:0] s1Low;
  logic                  s1Large;
  logic                  s1InRange;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1Low     <= '0;
      s1Large   <= 1'b0;
      s1InRange <= 1'b0;
    end else if (strobe.loadS1) begin
      s1Low     <= reqAddr[LargeShift-1:0];
      s1Large   <= pageLarge;
      s1InRange <= inRange;
    end
  end

  // entry checks and address merge
  logic         parityBad;
  logic         entryValid;
  logic [AddrW-1:0] merged;
  xlate_cause_e causeNext;

  assign parityBad  = ^sramRdData;
  assign entryValid = sramRdData[ValidBit];
  assign merged     = s1Large ? {sramRdData[FrameL-1:0], s1Low}
                              : {sramRdData[FrameS-1:0], s1Low[SmallShift-1:0]};

  always_comb begin
    if (!s1InRange)      causeNext = CAUSE_RANGE;
    else if (parityBad)  causeNext = CAUSE_PARITY;
    else if (!entryValid) causeNext = CAUSE_INVALID;
    else                 causeNext = CAUSE_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      respAddr  <= '0;
      respErr   <= 1'b0;
      respCause <= CAUSE_NONE;
    end else if (strobe.loadResp) begin
      respAddr  <= (causeNext == CAUSE_NONE) ? merged : '0;
      respErr   <= (causeNext != CAUSE_NONE);
      respCause <= causeNext;
    end
  end
endmodule

// File: rtl/gart_xlate.sv
`timescale 1ns/1ps
module gart_xlate
  import gart_pkg::*;
#(
  parameter int AddrW      = ADDR_W,
  parameter int SpaceLog2  = SPACE_LOG2,
  parameter int SmallShift = SMALL_SHIFT,
  parameter int LargeShift = LARGE_SHIFT,
  parameter int EntryW     = ENTRY_W,
  localparam int IdxW      = SpaceLog2 - SmallShift,
  localparam int BaseW     = AddrW - LargeShift
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              pageLarge,
  input  logic [BaseW-1:0]  apertureBase,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [AddrW-1:0]  reqAddr,
  output logic              sramRdEn,
  output logic [IdxW-1:0]   sramAddr,
  input  logic [EntryW-1:0] sramRdData,
  output logic              respValid,
  input  logic              respReady,
  output logic [AddrW-1:0]  respAddr,
  output logic              respErr,
  output logic [1:0]        respCause
);
  xlate_strobe_t strobe;
  logic          inRange;
  xlate_cause_e  causeInt;

  gart_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .reqValid  (reqValid),
    .inRange   (inRange),
    .respReady (respReady),
    .reqReady  (reqReady),
    .respValid (respValid),
    .strobe    (strobe)
  );

  gart_dpath #(
    .AddrW      (AddrW),
    .SpaceLog2  (SpaceLog2),
    .SmallShift (SmallShift),
    .LargeShift (LargeShift),
    .EntryW     (EntryW)
  ) u_dpath (
    .clk          (clk),
    .rst          (rst),
    .strobe       (strobe),
    .pageLarge    (pageLarge),
    .apertureBase (apertureBase),
    .reqAddr      (reqAddr),
    .sramRdData   (sramRdData),
    .inRange      (inRange),
    .sramAddr     (sramAddr),
    .respAddr     (respAddr),
    .respErr      (respErr),
    .respCause    (causeInt)
  );

  assign sramRdEn  = strobe.sramRd;
  assign respCause = causeInt;
endmodule

// File: rtl/gart_xlate_checker.sv
`timescale 1ns/1ps
module gart_xlate_checker #(
  parameter int AddrW = 40,
  parameter int BaseW = 18
)(
  input logic             clk,
  input logic             rst,
  input logic             reqValid,
  input logic             reqReady,
  input logic [BaseW-1:0] reqGran,
  input logic [BaseW-1:0] apertureBase,
  input logic             sramRdEn,
  input logic             respValid,
  input logic             respReady,
  input logic [AddrW-1:0] respAddr,
  input logic             respErr,
  input logic [1:0]       respCause
);
  // a table read only happens for a request being accepted
  assert_read_on_accept_R11: assert property (@(posedge clk) disable iff (rst)
    sramRdEn |-> (reqValid && reqReady));

  // an address below the base must not reach the table
  assert_no_read_below_base_R4: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqReady && (reqGran < apertureBase)) |-> !sramRdEn);

  // failed translations carry no address and a nonzero cause
  assert_error_clears_addr_R8: assert property (@(posedge clk) disable iff (rst)
    (respValid && respErr) |-> (respAddr == '0 && respCause != 2'd0));

  // stalled responses hold steady
  assert_stall_holds_R10: assert property (@(posedge clk) disable iff (rst)
    (respValid && !respReady) |=> (respValid && $stable(respAddr)
                                   && $stable(respErr) && $stable(respCause)));

  // an empty response slot never blocks new requests
  assert_ready_when_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !respValid |-> reqReady);
endmodule

bind gart_xlate gart_xlate_checker #(
  .AddrW (AddrW),
  .BaseW (BaseW)
) u_checker (
  .clk          (clk),
  .rst          (rst),
  .reqValid     (reqValid),
  .reqReady     (reqReady),
  .reqGran      (reqAddr[AddrW-1:LargeShift]),
  .apertureBase (apertureBase),
  .sramRdEn     (sramRdEn),
  .respValid    (respValid),
  .respReady    (respReady),
  .respAddr     (respAddr),
  .respErr      (respErr),
  .respCause    (respCause)
);

// File: tb/gart_xlate_test.sv
`timescale 1ns/1ps
module gart_xlate_test;
  localparam logic [17:0] BASE_G   = 18'h00400;          // 4 GB
  localparam logic [39:0] BASE_A   = {BASE_G, 22'b0};
  localparam logic [39:0] SPAN     = 40'h8_0000_0000;    // 32 GB

  logic        clk = 1'b0;
  logic        rst;
  logic        pageLarge;
  logic [17:0] apertureBase;
  logic        reqValid;
  logic        reqReady;
  logic [39:0] reqAddr;
  logic        sramRdEn;
  logic [22:0] sramAddr;
  logic [31:0] sramRdData;
  logic        respValid;
  logic        respReady;
  logic [39:0] respAddr;
  logic        respErr;
  logic [1:0]  respCause;

  always #2.5 clk = ~clk;  // 200 MHz

  gart_xlate uut (
    .clk(clk), .rst(rst), .pageLarge(pageLarge), .apertureBase(apertureBase),
    .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr),
    .sramRdEn(sramRdEn), .sramAddr(sramAddr), .sramRdData(sramRdData),
    .respValid(respValid), .respReady(respReady), .respAddr(respAddr),
    .respErr(respErr), .respCause(respCause)
  );

  int vectors = 0;
  int fails   = 0;
  int cycles  = 0;
  int rdSeen  = 0;
  int rdWant  = 0;
  bit done    = 0;

  logic [39:0] qAddr[$];
  logic [1:0]  qCause[$];

  logic        prevStall = 1'b0;
  logic [39:0] prevAddr;
  logic [1:0]  prevCause;
  logic        prevErr;

  // table contents are a function of the index
  function automatic logic [31:0] entryFn(input logic [22:0] idx);
    logic [27:0] frame;
    logic        vld;
    logic [31:0] e;
    frame = 28'(idx * 23'h09E37 + 23'd5) ^ {5'h0, idx};
    vld   = (idx % 7) != 3;
    e     = {1'b0, vld, 2'b01, frame};
    e[31] = ^e[30:0];
    if ((idx % 11) == 5) e[31] = ~e[31];
    return e;
  endfunction

  // SRAM with one-cycle latency, output held between reads
  always @(posedge clk) if (sramRdEn) sramRdData <= entryFn(sramAddr);

  function automatic void refModel(input logic [39:0] a, input logic lg,
                                   output logic inr, output logic [22:0] idx,
                                   output logic [39:0] pa, output logic [1:0] cause);
    logic [40:0] off;
    logic [31:0] e;
    off = {1'b0, a} - {1'b0, BASE_A};
    inr = !off[40] && (off[39:35] == 5'd0);
    idx = lg ? {10'b0, off[34:22]} : off[34:12];
    e   = entryFn(idx);
    pa  = '0;
    if (!inr)        cause = 2'd1;
    else if (^e)     cause = 2'd2;
    else if (!e[30]) cause = 2'd3;
    else begin
      cause = 2'd0;
      pa    = lg ? {e[17:0], a[21:0]} : {e[27:0], a[11:0]};
    end
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cycles);
    end
  endtask

  function automatic string causeTag(input logic [1:0] c);
    case (c)
      2'd0: return "R7";
      2'd1: return "R4";
      2'd2: return "R5";
      default: return "R6";
    endcase
  endfunction

  // one clock: drive at the falling edge, compare once settled
  task automatic step(input logic v, input logic [39:0] a, input logic lg,
                      input logic rr);
    logic        inr;
    logic [22:0] idx;
    logic [39:0] pa;
    logic [1:0]  cause;
    logic        accept;
    @(negedge clk);
    reqValid = v; reqAddr = a; pageLarge = lg; respReady = rr;
    #1;
    if (prevStall) begin
      chk(respValid && respAddr == prevAddr && respCause == prevCause
          && respErr == prevErr, "R10 stall hold", {respValid, respAddr},
          {1'b1, prevAddr});
    end
    refModel(a, lg, inr, idx, pa, cause);
    accept = v && reqReady;
    chk(sramRdEn == (accept && inr), "R11 read enable", sramRdEn, accept && inr);
    if (sramRdEn) begin
      rdSeen++;
      chk(sramAddr == idx, lg ? "R3 large index" : "R2 small index", sramAddr, idx);
    end
    if (accept && inr) rdWant++;
    if (accept) begin
      qAddr.push_back(pa);
      qCause.push_back(cause);
    end
    if (respValid && qCause.size() == 0) begin
      chk(1'b0, "R9 unexpected response", respValid, 0);
    end else if (respValid && respReady) begin
      logic [39:0] ea;
      logic [1:0]  ec;
      ea = qAddr.pop_front();
      ec = qCause.pop_front();
      chk(respCause == ec, causeTag(ec), respCause, ec);
      chk(respAddr == ea, ec == 0 ? "R7 address" : "R8 zero address", respAddr, ea);
      chk(respErr == (ec != 0), "R8 error flag", respErr, ec != 0);
    end
    prevStall = respValid && !respReady;
    prevAddr  = respAddr;
    prevCause = respCause;
    prevErr   = respErr;
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      fails++;
      vectors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finishRun();
    end
  end

  initial begin
    rst = 1'b1; reqValid = 1'b0; reqAddr = '0; pageLarge = 1'b0;
    respReady = 1'b1; apertureBase = BASE_G; sramRdData = '0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    chk(respValid == 1'b0, "R1 respValid after reset", respValid, 0);
    chk(reqReady == 1'b1, "R1 reqReady after reset", reqReady, 1);

    // R9: latency of a lone request
    step(1'b1, BASE_A + 40'h1234_5678, 1'b0, 1'b1);
    step(1'b0, '0, 1'b0, 1'b1);
    chk(respValid == 1'b0, "R9 not yet valid", respValid, 0);
    step(1'b0, '0, 1'b0, 1'b1);
    chk(qCause.size() == 0, "R9 response after two edges", qCause.size(), 0);

    // R4: range boundaries in both page sizes
    for (int lg = 0; lg < 2; lg++) begin
      step(1'b1, BASE_A, lg[0], 1'b1);
      step(1'b1, BASE_A + SPAN - 40'd1, lg[0], 1'b1);
      step(1'b1, BASE_A + SPAN, lg[0], 1'b1);
      step(1'b1, BASE_A - 40'd1, lg[0], 1'b1);
    end

    // R11: same address back to back still reads each time
    repeat (3) step(1'b1, BASE_A + 40'h0_0040_3000, 1'b0, 1'b1);
    // R5/R6: walk small indexes to hit bad parity and invalid entries
    for (int i = 0; i < 24; i++)
      step(1'b1, BASE_A + (40'(i) << 12) + 40'h7A, 1'b0, 1'b1);
    // R12: page size flips while requests are in flight
    for (int i = 0; i < 16; i++)
      step(1'b1, BASE_A + (40'(i) << 22) + 40'h1_2345, i[0], i[1]);
    repeat (4) step(1'b0, '0, 1'b0, 1'b1);

    // mixed random traffic with response stalls (R2, R3, R10, R12)
    for (int n = 0; n < 3000; n++) begin
      logic [39:0] a;
      int sel;
      sel = $urandom_range(0, 9);
      if (sel < 8)       a = BASE_A + ({8'h0, $urandom()} | (40'($urandom_range(0, 7)) << 32));
      else if (sel == 8) a = BASE_A + SPAN + 40'($urandom_range(0, 65535));
      else               a = BASE_A - 40'd1 - 40'($urandom_range(0, 65535));
      step($urandom_range(0, 4) != 0, a, $urandom_range(0, 1) == 1,
           $urandom_range(0, 9) < 7);
    end
    while (qCause.size() != 0 && cycles < 140000) step(1'b0, '0, 1'b0, 1'b1);
    chk(qCause.size() == 0, "R9 all responses drained", qCause.size(), 0);
    chk(rdSeen == rdWant, "R11 read count", rdSeen, rdWant);
    done = 1;
    finishRun();
  end
endmodule